// File: doc/BRIEF.md
# Bias Chain Loader

This controller sits on the host side of a serial bias-programming chain. It takes a stream of bias bytes over a valid/ready handshake and drives three wires into the chain: a data bit, a shift clock and an active-low latch strobe. Each bias arrives as three bytes, most significant byte first. The first bias in the stream is the one that ends up at the far end of the chain. Every bit is placed on the data wire while the shift clock is low, and the clock is then pulsed high and back low. Bits go out most significant first.

When the bias bits are done, the controller appends a 4-bit test field and an 8-bit buffer-bias field, both taken from configuration inputs. It then holds the clock low for one tick and drives the latch low for a programmable number of ticks. When the latch returns high it issues a one-cycle done pulse. All bit timing is counted in ticks of a programmable divider: one tick lasts `cfg_div + 1` system clock cycles, so the bit rate is `f_clk / (2*(cfg_div+1))`. At 50 MHz, a setting of 82 gives roughly 300 kHz and a setting of 7 gives roughly 3 MHz. A power-down request is registered and passed through to the chain.

Top module: `bias_chain_loader`

## Requirements
- R1: While reset is asserted and in the cycle after it is released: `bias_clk`=0, `bias_latch`=1, `bias_bit`=0, `busy`=0, `done`=0, `s_ready`=0 and `bias_pd`=0.
- R2: A load consumes NUM_BIAS*3 bytes in arrival order. Each byte is shifted out bit 7 first and bit 0 last, one bit per `bias_clk` pulse.
- R3: For each bit, `bias_bit` takes its new value while `bias_clk` is low. The clock stays low for D = `cfg_div`+1 cycles and then high for D cycles. `bias_bit` does not change while `bias_clk` is high.
- R4: `s_ready` is high for exactly one cycle before each byte is taken, only during a load. It is never high while `bias_clk` is high. Exactly NUM_BIAS*3 handshakes occur per load.
- R5: After the final clock pulse, `bias_clk` stays low for D cycles. `bias_latch` then goes low for L*D cycles, where L is the latch-tick setting, and then returns high.
- R6: `busy` rises in the cycle after `start` is accepted and stays high until the cycle in which `bias_latch` returns high. In that cycle `done` is high for exactly one cycle and `busy` is low.
- R7: A `start` pulse while `busy` is high has no effect. The running load keeps its waveform and no second load follows.
- R8: After a load, `bias_clk` stays low and `bias_bit` keeps the last bit shifted, which is bit 0 of the buffer-bias field.
- R9: `bias_pd` equals `pwr_down_in` delayed by one cycle.
- R10: A latch-tick setting of 0 is treated as 1 tick.
- R11: `cfg_div`, `cfg_latch_ticks`, `cfg_test_bits` and `cfg_buf_bits` are captured when `start` is accepted. Changes to them during a load have no effect on that load.
- R12: After the bias bytes, `cfg_test_bits` is shifted bit 3 first, then `cfg_buf_bits` bit 7 first, with no byte handshake between them. This gives 24*NUM_BIAS+12 clock pulses in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (accepted only when idle) |
| cfg_div | input | DIV_W | Tick divider; one tick = cfg_div+1 cycles |
| cfg_latch_ticks | input | LAT_W | Latch low time in ticks (0 means 1) |
| cfg_test_bits | input | 4 | Test-cell field appended after the biases |
| cfg_buf_bits | input | 8 | Buffer-bias field appended last |
| pwr_down_in | input | 1 | Power-down request from control register |
| s_data | input | 8 | Bias byte |
| s_valid | input | 1 | Bias byte valid |
| s_ready | output | 1 | Controller takes the byte this cycle if valid |
| bias_bit | output | 1 | Serial data into the chain |
| bias_clk | output | 1 | Shift clock into the chain |
| bias_latch | output | 1 | Latch strobe, low = transparent |
| bias_pd | output | 1 | Registered power-down to the chain |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions take for granted that reset is applied before use and that the stream source may stall `s_valid` freely. A stall only stretches the byte-wait cycle, so none of the clock, data or latch relations they check depend on when bytes arrive. The cycle-exact reference in the bench does depend on arrival timing, so the stimulus keeps `s_valid` high with the next byte always presented. Each byte wait then lasts exactly one cycle. Divider values stay small enough that a full 300 kHz load still fits in the run.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

    localparam int BYTE_W        = 8;
    localparam int BYTES_PER_BIAS = 3;
    localparam int TEST_BITS     = 4;
    localparam int BUFB_BITS     = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_HIGH,
        ST_GAP,
        ST_LATCH,
        ST_DONE
    } bcl_state_e;

    typedef enum logic [1:0] {
        SEG_BIAS,
        SEG_TEST,
        SEG_BUFB
    } bcl_seg_e;

    typedef struct packed {
        logic [TEST_BITS-1:0] test;
        logic [BUFB_BITS-1:0] bufb;
    } bcl_trail_t;

    // divider setting for a wanted bit rate (two ticks per bit)
    function automatic int div_for_rate(input int clk_hz, input int bit_hz);
        return clk_hz / (2 * bit_hz) - 1;
    endfunction

endpackage

// File: rtl/bcl_tick_gen.sv
module bcl_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt_q <= div)); // R3

endmodule

// File: rtl/bcl_shifter.sv
module bcl_shifter #(
    parameter int W     = 8,
    parameter int LEN_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [W-1:0]     load_word,
    input  logic [LEN_W-1:0] load_len,
    input  logic             adv,
    output logic             bit_out,
    output logic             last
);

    logic [W-1:0]     sh_q;
    logic [LEN_W-1:0] left_q;
    logic             bit_q;

    assign bit_out = bit_q;
    assign last    = (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
            bit_q  <= 1'b0;
        end else if (load) begin
            bit_q  <= load_word[W-1];
            sh_q   <= load_word << 1;
            left_q <= load_len;
        end else if (adv) begin
            bit_q  <= sh_q[W-1];
            sh_q   <= sh_q << 1;
            left_q <= left_q - 1'b1;
        end
    end

    AST_ADV_HAS_BITS: assert property (@(posedge clk) disable iff (rst)
        adv |-> !last); // R2

    AST_LOAD_ADV_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(load && adv)); // R12

endmodule

// File: rtl/bias_chain_loader.sv
module bias_chain_loader
    import bcl_pkg::*;
#(
    parameter int NUM_BIAS = 12,
    parameter int DIV_W    = 16,
    parameter int LAT_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic [LAT_W-1:0]     cfg_latch_ticks,
    input  logic [TEST_BITS-1:0] cfg_test_bits,
    input  logic [BUFB_BITS-1:0] cfg_buf_bits,
    input  logic                 pwr_down_in,
    input  logic [BYTE_W-1:0]    s_data,
    input  logic                 s_valid,
    output logic                 s_ready,
    output logic                 bias_bit,
    output logic                 bias_clk,
    output logic                 bias_latch,
    output logic                 bias_pd,
    output logic                 busy,
    output logic                 done
);

    localparam int NBYTES = NUM_BIAS * BYTES_PER_BIAS;
    localparam int BC_W   = $clog2(NBYTES + 1);
    localparam int LEN_W  = $clog2(BYTE_W);

    bcl_state_e       state_q;
    bcl_seg_e         seg_q;
    logic [BC_W-1:0]  bytes_left_q;
    logic [LAT_W-1:0] lat_left_q;
    logic [DIV_W-1:0] div_q;
    logic [LAT_W-1:0] lat_q;
    bcl_trail_t       trail_q;
    logic             pd_q;

    logic              tick;
    logic              tick_en;
    logic              sh_load;
    logic              sh_adv;
    logic [BYTE_W-1:0] sh_word;
    logic [LEN_W-1:0]  sh_len;
    logic              sh_last;
    logic              sh_bit;

    assign tick_en = (state_q == ST_SETUP) || (state_q == ST_HIGH) ||
                     (state_q == ST_GAP)   || (state_q == ST_LATCH);

    bcl_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (tick_en),
        .div  (div_q),
        .tick (tick)
    );

    bcl_shifter #(.W(BYTE_W), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .load_word (sh_word),
        .load_len  (sh_len),
        .adv       (sh_adv),
        .bit_out   (sh_bit),
        .last      (sh_last)
    );

    // shifter feed: bias bytes, then test field, then buffer-bias field
    always_comb begin
        sh_load = 1'b0;
        sh_adv  = 1'b0;
        sh_word = '0;
        sh_len  = '0;
        case (state_q)
            ST_FETCH: begin
                if (s_valid) begin
                    sh_load = 1'b1;
                    sh_word = s_data;
                    sh_len  = LEN_W'(BYTE_W - 1);
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (!sh_last) begin
                        sh_adv = 1'b1;
                    end else if (seg_q == SEG_BIAS && bytes_left_q == '0) begin
                        sh_load = 1'b1;
                        sh_word = {trail_q.test, {(BYTE_W-TEST_BITS){1'b0}}};
                        sh_len  = LEN_W'(TEST_BITS - 1);
                    end else if (seg_q == SEG_TEST) begin
                        sh_load = 1'b1;
                        sh_word = trail_q.bufb;
                        sh_len  = LEN_W'(BUFB_BITS - 1);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            seg_q        <= SEG_BIAS;
            bytes_left_q <= '0;
            lat_left_q   <= '0;
            div_q        <= '0;
            lat_q        <= '0;
            trail_q      <= '0;
            pd_q         <= 1'b0;
        end else begin
            pd_q <= pwr_down_in;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        div_q        <= cfg_div;
                        lat_q        <= (cfg_latch_ticks == '0) ? LAT_W'(1) : cfg_latch_ticks;
                        trail_q      <= '{test: cfg_test_bits, bufb: cfg_buf_bits};
                        bytes_left_q <= BC_W'(NBYTES - 1);
                        seg_q        <= SEG_BIAS;
                        state_q      <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (s_valid) state_q <= ST_SETUP;
                end
                ST_SETUP: begin
                    if (tick) state_q <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (!sh_last) begin
                            state_q <= ST_SETUP;
                        end else begin
                            case (seg_q)
                                SEG_BIAS: begin
                                    if (bytes_left_q != '0) begin
                                        bytes_left_q <= bytes_left_q - 1'b1;
                                        state_q      <= ST_FETCH;
                                    end else begin
                                        seg_q   <= SEG_TEST;
                                        state_q <= ST_SETUP;
                                    end
                                end
                                SEG_TEST: begin
                                    seg_q   <= SEG_BUFB;
                                    state_q <= ST_SETUP;
                                end
                                default: state_q <= ST_GAP;
                            endcase
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        lat_left_q <= lat_q;
                        state_q    <= ST_LATCH;
                    end
                end
                ST_LATCH: begin
                    if (tick) begin
                        if (lat_left_q == LAT_W'(1)) state_q <= ST_DONE;
                        else                         lat_left_q <= lat_left_q - 1'b1;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign s_ready    = (state_q == ST_FETCH);
    assign bias_clk   = (state_q == ST_HIGH);
    assign bias_latch = (state_q != ST_LATCH);
    assign bias_bit   = sh_bit;
    assign bias_pd    = pd_q;
    assign busy       = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done       = (state_q == ST_DONE);

    AST_BIT_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        bias_clk |-> $stable(bias_bit)); // R3

    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bias_clk); // R8

    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bias_latch |-> (!bias_clk && !s_ready && busy)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R6

    AST_READY_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (busy && !bias_clk && bias_latch)); // R4

    AST_LATCH_RISE_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(bias_latch) |-> done); // R6

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && !s_ready && start) |=> busy || done); // R7

endmodule

// File: tb/bias_chain_loader_tb.sv
module bias_chain_loader_tb;
    import bcl_pkg::*;

    localparam int NUM_BIAS = 12;
    localparam int NB       = NUM_BIAS * 3;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] cfg_div = '0;
    logic [7:0]  cfg_latch_ticks = '0;
    logic [3:0]  cfg_test_bits = '0;
    logic [7:0]  cfg_buf_bits = '0;
    logic        pwr_down_in = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_valid = 1'b0;
    logic        s_ready, bias_bit, bias_clk, bias_latch, bias_pd, busy, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic model_bit = 1'b0;

    always #10 clk = ~clk;

    bias_chain_loader #(.NUM_BIAS(NUM_BIAS)) u_dut (
        .clk(clk), .rst(rst), .start(start), .cfg_div(cfg_div),
        .cfg_latch_ticks(cfg_latch_ticks), .cfg_test_bits(cfg_test_bits),
        .cfg_buf_bits(cfg_buf_bits), .pwr_down_in(pwr_down_in),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .bias_bit(bias_bit), .bias_clk(bias_clk), .bias_latch(bias_latch),
        .bias_pd(bias_pd), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // expected entry: {clk, bit, latch, busy, done, ready}
    task automatic push(ref logic [5:0] q[$], input int n, input logic c,
                        input logic b, input logic l, input logic bz,
                        input logic dn, input logic rd);
        for (int i = 0; i < n; i++) q.push_back({c, b, l, bz, dn, rd});
    endtask

    task automatic push_bits(ref logic [5:0] q[$], input logic [7:0] v,
                             input int nbits, input int d);
        for (int k = nbits - 1; k >= 0; k--) begin
            model_bit = v[k];
            push(q, d, 1'b0, model_bit, 1'b1, 1'b1, 1'b0, 1'b0);
            push(q, d, 1'b1, model_bit, 1'b1, 1'b1, 1'b0, 1'b0);
        end
    endtask

    task automatic run_load(input string lbl, input int div, input int lat,
                            input logic [3:0] tst, input logic [7:0] bfb,
                            input bit disturb);
        logic [5:0] q[$];
        logic [7:0] stream[NB];
        logic [5:0] e;
        int idx;
        bit hs;
        int cyc;
        int d;
        int lp;
        d  = div + 1;
        lp = (lat == 0) ? 1 : lat;
        for (int i = 0; i < NB; i++) stream[i] = 8'((i * 37) ^ (div * 11) ^ 8'hA5);
        // reference waveform, one entry per cycle after start is taken
        for (int i = 0; i < NB; i++) begin
            push(q, 1, 1'b0, model_bit, 1'b1, 1'b1, 1'b0, 1'b1);
            push_bits(q, stream[i], 8, d);
        end
        push_bits(q, {4'b0, tst}, 4, d);
        push_bits(q, bfb, 8, d);
        push(q, d, 1'b0, model_bit, 1'b1, 1'b1, 1'b0, 1'b0);
        push(q, lp * d, 1'b0, model_bit, 1'b0, 1'b1, 1'b0, 1'b0);
        push(q, 1, 1'b0, model_bit, 1'b1, 1'b0, 1'b1, 1'b0);
        push(q, 6, 1'b0, model_bit, 1'b1, 1'b0, 1'b0, 1'b0);

        @(negedge clk);
        cfg_div = 16'(div); cfg_latch_ticks = 8'(lat);
        cfg_test_bits = tst; cfg_buf_bits = bfb;
        idx = 0; hs = 0; s_valid = 1'b1; s_data = stream[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (q.size() > 0) begin
            if (hs) idx++;
            s_valid = (idx < NB);
            s_data  = (idx < NB) ? stream[idx] : 8'h00;
            hs      = s_ready && s_valid;
            e = q.pop_front();
            checks++;
            if ({bias_clk, bias_bit, bias_latch, busy, done, s_ready} !== e) begin
                errors++;
                $display("FAIL %s cycle %0d R2 R3 R4 R5 R6 R12 clk/bit/latch/busy/done/ready actual %b expected %b",
                         lbl, cyc, {bias_clk, bias_bit, bias_latch, busy, done, s_ready}, e);
            end
            if (disturb) begin
                if (cyc == 40) start = 1'b1;          // R7: restart attempt
                if (cyc == 41) start = 1'b0;
                if (cyc == 60) begin                  // R11: config changes mid-load
                    cfg_div = 16'(div + 3); cfg_latch_ticks = 8'(lat + 2);
                    cfg_test_bits = ~tst; cfg_buf_bits = ~bfb;
                end
            end
            cyc++;
            @(negedge clk);
        end
        check1({lbl, " R4 handshake count ok"}, (idx == NB), 1'b1);
        // R8: idle levels hold after the load
        for (int i = 0; i < 3; i++) begin
            check1({lbl, " R8 idle clk"}, bias_clk, 1'b0);
            check1({lbl, " R8 held bit"}, bias_bit, bfb[0]);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check1("R1 clk in reset", bias_clk, 1'b0);
        check1("R1 latch in reset", bias_latch, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check1("R1 clk", bias_clk, 1'b0);
        check1("R1 latch", bias_latch, 1'b1);
        check1("R1 bit", bias_bit, 1'b0);
        check1("R1 busy", busy, 1'b0);
        check1("R1 done", done, 1'b0);
        check1("R1 ready", s_ready, 1'b0);
        check1("R1 pd", bias_pd, 1'b0);

        run_load("R3 min divider", 0, 1, 4'b1010, 8'hC3, 1'b0);
        run_load("R10 zero latch ticks", 1, 0, 4'b0110, 8'h5A, 1'b0);
        run_load("R7 R11 disturbed load", div_for_rate(50000000, 3000000), 3,
                 4'b1001, 8'h81, 1'b1);
        run_load("R2 R12 300kHz load", div_for_rate(50000000, 300000), 2,
                 4'b0011, 8'h7E, 1'b0);

        // R9: power-down pass-through with one-cycle delay
        for (int i = 0; i < 6; i++) begin
            logic v;
            v = logic'((i * 5 + 1) % 3 == 0);
            pwr_down_in = v;
            @(negedge clk);
            check1("R9 pd follow", bias_pd, v);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule